// File: doc/BRIEF.md
# Store Queue Writeback Controller

This block holds stores in a circular queue and drains them to a data-cache request port strictly in program order. Stores are allocated at the tail with a sequence number, address, data, size and two type flags (swap, locked). Once a store has been committed it is marked ready. The entry at the head is then sent to the cache with a command chosen from its type flags.

A store-conditional whose reservation check fails (the `resv_ok` input is low) never reaches the cache. It is retired locally in the same step. When the cache refuses a request, the block enters a blocked state and keeps a copy of that request. It sends the copy again on each retry pulse until the cache accepts it.

A squash removes every entry younger than a given sequence number. The tail pointer and the occupancy count roll back to match. Every retired entry produces a completion pulse one cycle after the step that retired it.

Top module: `sqwb_writeback_ctrl`

## Requirements
- R1: After reset, `sq_count` is 0, `sq_full`, `store_blocked`, `req_valid` and `done_valid` are 0, and `sq_tail_idx` is 0.
- R2: An allocation writes the entry at `sq_tail_idx` and advances the tail modulo DEPTH, which raises `sq_count` by one. `sq_full` is high when the count equals DEPTH, and an allocation while full is ignored, leaving tail and count unchanged.
- R3: A request is presented only for the head entry, and only when that entry is valid, has been committed and the port is not blocked. `req_addr`, `req_data` and `req_size` carry that entry's fields, and a younger committed entry never goes out ahead of an uncommitted older one.
- R4: `req_cmd` is 2 (swap) when the entry is a swap, else 1 (store-conditional) when it is locked, else 0 (plain write). Code 3 is never produced.
- R5: For a locked, non-swap head entry presented while `resv_ok` is 0, `req_valid` stays low. The entry is retired and the head advances at the next clock edge.
- R6: One cycle after an entry is retired, `done_valid` pulses for one cycle with that entry's index and sequence number. `done_sc_fail` is 1 only for a locally retired failed store-conditional.
- R7: A fresh request that sees `req_accept` low sets `store_blocked` at the next edge and keeps a copy of the refused request.
- R8: While blocked, `req_valid` is high only during `retry_pulse`, and it then carries the held request, even if later entries are ready. A retry that is accepted clears `store_blocked` at the next edge.
- R9: The head advances only when the cache accepts a request (or for R5). A refused request or an unaccepted retry leaves `sq_count` unchanged and produces no completion.
- R10: A squash removes every valid entry whose sequence number is greater than `squash_seq`. The tail moves back by the number removed, and the count drops by the same number. An allocation in the squash cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQW | Sequence number of the new store |
| alloc_addr | input | AW | Store address |
| alloc_data | input | DW | Store data |
| alloc_size | input | 2 | log2 of the access size in bytes |
| alloc_swap | input | 1 | Entry is an atomic swap |
| alloc_locked | input | 1 | Entry is a store-conditional |
| sq_tail_idx | output | log2(DEPTH) | Index the next allocation will take |
| sq_count | output | log2(DEPTH)+1 | Occupied entries |
| sq_full | output | 1 | Queue is full |
| commit_valid | input | 1 | Mark an entry ready to write back |
| commit_idx | input | log2(DEPTH) | Entry to mark |
| squash_valid | input | 1 | Squash younger stores |
| squash_seq | input | SEQW | Entries with a greater number are removed |
| resv_ok | input | 1 | Reservation check result for store-conditionals |
| req_valid | output | 1 | Cache request present |
| req_cmd | output | 2 | 0 write, 1 store-conditional, 2 swap |
| req_addr | output | AW | Request address |
| req_data | output | DW | Request data |
| req_size | output | 2 | Request size code |
| req_accept | input | 1 | Cache takes the request this cycle |
| retry_pulse | input | 1 | Cache invites a resend |
| store_blocked | output | 1 | A refused request is being held |
| done_valid | output | 1 | Completion pulse |
| done_idx | output | log2(DEPTH) | Index of the retired entry |
| done_seq | output | SEQW | Sequence number of the retired entry |
| done_sc_fail | output | 1 | Completion was a failed store-conditional |

## Verification
The bench builds the block with DEPTH = 4, AW = 16, DW = 32 and SEQW = 8. With a four-entry queue, a few allocations are enough to fill it, to try an allocation while it is full, and to wrap both pointers several times. Squash roll-back across the wrap point also comes within reach. The narrow address and data widths keep the field checks short without losing any case.

// File: rtl/sqwb_pkg.sv
// Shared definitions for the store queue writeback controller.
// Assumes: the cache port decodes the command codes below.
package sqwb_pkg;

    // Cache command codes presented on req_cmd.
    typedef enum logic [1:0] {
        CMD_WRITE  = 2'd0,
        CMD_STCOND = 2'd1,
        CMD_SWAP   = 2'd2
    } mem_cmd_e;

endpackage

// File: rtl/sqwb_cmd_select.sv
// Picks the cache command for one store entry from its type flags.
// Swap wins over locked; an entry with neither flag is a plain write.
// Assumes: purely combinational, no state.
module sqwb_cmd_select
    import sqwb_pkg::*;
(
    input  logic       is_swap,
    input  logic       is_locked,
    output logic [1:0] cmd,
    output logic       is_stcond
);

    // Priority decode of the command code.
    always_comb begin
        if (is_swap) begin
            cmd = CMD_SWAP;
        end else if (is_locked) begin
            cmd = CMD_STCOND;
        end else begin
            cmd = CMD_WRITE;
        end
    end

    // Store-conditional only when locked and not a swap.
    assign is_stcond = is_locked && !is_swap;

endmodule

// File: rtl/sqwb_entry_store.sv
// Circular store queue: allocation at the tail, commit marking by index,
// retirement at the head and one-cycle squash roll-back of the tail.
// Assumes: DEPTH is a power of two; sequence numbers rise from head to
// tail without wrapping; free_en is raised only for a valid, ready head;
// squash never reaches a committed entry.
module sqwb_entry_store #(
    parameter  int DEPTH = 8,
    parameter  int AW    = 32,
    parameter  int DW    = 64,
    parameter  int SEQW  = 16,
    localparam int IDXW  = $clog2(DEPTH),
    localparam int CNTW  = IDXW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_valid,
    input  logic [SEQW-1:0] alloc_seq,
    input  logic [AW-1:0]   alloc_addr,
    input  logic [DW-1:0]   alloc_data,
    input  logic [1:0]      alloc_size,
    input  logic            alloc_swap,
    input  logic            alloc_locked,
    input  logic            commit_valid,
    input  logic [IDXW-1:0] commit_idx,
    input  logic            free_en,
    input  logic            squash_valid,
    input  logic [SEQW-1:0] squash_seq,
    output logic [IDXW-1:0] tail_idx,
    output logic [IDXW-1:0] head_idx,
    output logic [CNTW-1:0] count,
    output logic            full,
    output logic            head_valid,
    output logic            head_ready,
    output logic [SEQW-1:0] head_seq,
    output logic [AW-1:0]   head_addr,
    output logic [DW-1:0]   head_data,
    output logic [1:0]      head_size,
    output logic            head_swap,
    output logic            head_locked
);

    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] rdy_q;
    logic [DEPTH-1:0] swap_q;
    logic [DEPTH-1:0] lock_q;
    logic [DEPTH-1:0] kill;
    logic [SEQW-1:0]  seq_q  [DEPTH];
    logic [AW-1:0]    addr_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic [1:0]       size_q [DEPTH];
    logic [IDXW-1:0]  head_q;
    logic [IDXW-1:0]  tail_q;
    logic [CNTW-1:0]  cnt_q;
    logic [CNTW-1:0]  kill_cnt;
    logic             alloc_ok;

    // Full flag and allocation gate (squash has priority over allocation).
    assign full     = (cnt_q == CNTW'(DEPTH));
    assign alloc_ok = alloc_valid && !full && !squash_valid;

    // Mark younger entries for removal and count them.
    always_comb begin
        kill_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            kill[i] = squash_valid && vld_q[i] && (seq_q[i] > squash_seq)
                      && !(free_en && (head_q == IDXW'(i)));
            kill_cnt = kill_cnt + CNTW'(kill[i]);
        end
    end

    // Head, tail and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (free_en) begin
                head_q <= head_q + IDXW'(1);
            end
            if (squash_valid) begin
                tail_q <= tail_q - kill_cnt[IDXW-1:0];
            end else if (alloc_ok) begin
                tail_q <= tail_q + IDXW'(1);
            end
            cnt_q <= cnt_q + CNTW'(alloc_ok) - CNTW'(free_en) - kill_cnt;
        end
    end

    // Per-entry state: allocate, squash, retire or mark ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            rdy_q  <= '0;
            swap_q <= '0;
            lock_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                seq_q[i]  <= '0;
                addr_q[i] <= '0;
                data_q[i] <= '0;
                size_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc_ok && (tail_q == IDXW'(i))) begin
                    vld_q[i]  <= 1'b1;
                    rdy_q[i]  <= 1'b0;
                    swap_q[i] <= alloc_swap;
                    lock_q[i] <= alloc_locked;
                    seq_q[i]  <= alloc_seq;
                    addr_q[i] <= alloc_addr;
                    data_q[i] <= alloc_data;
                    size_q[i] <= alloc_size;
                end else if (kill[i] || (free_en && (head_q == IDXW'(i)))) begin
                    vld_q[i] <= 1'b0;
                    rdy_q[i] <= 1'b0;
                end else if (commit_valid && (commit_idx == IDXW'(i)) && vld_q[i]) begin
                    rdy_q[i] <= 1'b1;
                end
            end
        end
    end

    // Head entry view for the issue logic.
    assign tail_idx    = tail_q;
    assign head_idx    = head_q;
    assign count       = cnt_q;
    assign head_valid  = vld_q[head_q];
    assign head_ready  = rdy_q[head_q];
    assign head_seq    = seq_q[head_q];
    assign head_addr   = addr_q[head_q];
    assign head_data   = data_q[head_q];
    assign head_size   = size_q[head_q];
    assign head_swap   = swap_q[head_q];
    assign head_locked = lock_q[head_q];

endmodule

// File: rtl/sqwb_retry_hold.sv
// Keeps one refused cache request and the blocked flag until a retry is
// accepted.
// Assumes: capture_en and release_en are never high together.
module sqwb_retry_hold #(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_en,
    input  logic          release_en,
    input  logic [1:0]    in_cmd,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  logic [1:0]    in_size,
    output logic          blocked,
    output logic [1:0]    held_cmd,
    output logic [AW-1:0] held_addr,
    output logic [DW-1:0] held_data,
    output logic [1:0]    held_size
);

    // Capture on refusal, drop the copy once a resend is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked   <= 1'b0;
            held_cmd  <= '0;
            held_addr <= '0;
            held_data <= '0;
            held_size <= '0;
        end else if (capture_en) begin
            blocked   <= 1'b1;
            held_cmd  <= in_cmd;
            held_addr <= in_addr;
            held_data <= in_data;
            held_size <= in_size;
        end else if (release_en) begin
            blocked   <= 1'b0;
            held_cmd  <= '0;
            held_addr <= '0;
            held_data <= '0;
            held_size <= '0;
        end
    end

endmodule

// File: rtl/sqwb_writeback_ctrl.sv
// Store queue writeback controller. Drains committed stores in order to a
// cache request port, chooses the command per entry, retires failed
// store-conditionals locally, replays a refused request on retry, and
// reports each retirement one cycle later.
// Assumes: req_accept is only meaningful while req_valid is high.
module sqwb_writeback_ctrl #(
    parameter  int DEPTH = 8,
    parameter  int AW    = 32,
    parameter  int DW    = 64,
    parameter  int SEQW  = 16,
    localparam int IDXW  = $clog2(DEPTH),
    localparam int CNTW  = IDXW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_valid,
    input  logic [SEQW-1:0] alloc_seq,
    input  logic [AW-1:0]   alloc_addr,
    input  logic [DW-1:0]   alloc_data,
    input  logic [1:0]      alloc_size,
    input  logic            alloc_swap,
    input  logic            alloc_locked,
    output logic [IDXW-1:0] sq_tail_idx,
    output logic [CNTW-1:0] sq_count,
    output logic            sq_full,
    input  logic            commit_valid,
    input  logic [IDXW-1:0] commit_idx,
    input  logic            squash_valid,
    input  logic [SEQW-1:0] squash_seq,
    input  logic            resv_ok,
    output logic            req_valid,
    output logic [1:0]      req_cmd,
    output logic [AW-1:0]   req_addr,
    output logic [DW-1:0]   req_data,
    output logic [1:0]      req_size,
    input  logic            req_accept,
    input  logic            retry_pulse,
    output logic            store_blocked,
    output logic            done_valid,
    output logic [IDXW-1:0] done_idx,
    output logic [SEQW-1:0] done_seq,
    output logic            done_sc_fail
);

    logic [IDXW-1:0] head_idx;
    logic            head_valid;
    logic            head_ready;
    logic [SEQW-1:0] head_seq;
    logic [AW-1:0]   head_addr;
    logic [DW-1:0]   head_data;
    logic [1:0]      head_size;
    logic            head_swap;
    logic            head_locked;
    logic [1:0]      head_cmd;
    logic            head_is_sc;
    logic            blocked;
    logic [1:0]      held_cmd;
    logic [AW-1:0]   held_addr;
    logic [DW-1:0]   held_data;
    logic [1:0]      held_size;
    logic            issue_ok;
    logic            sc_fail_now;
    logic            fresh_req;
    logic            accepted;
    logic            free_en;
    logic            capture_en;
    logic            release_en;

    sqwb_entry_store #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .DW    (DW),
        .SEQW  (SEQW)
    ) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_valid  (alloc_valid),
        .alloc_seq    (alloc_seq),
        .alloc_addr   (alloc_addr),
        .alloc_data   (alloc_data),
        .alloc_size   (alloc_size),
        .alloc_swap   (alloc_swap),
        .alloc_locked (alloc_locked),
        .commit_valid (commit_valid),
        .commit_idx   (commit_idx),
        .free_en      (free_en),
        .squash_valid (squash_valid),
        .squash_seq   (squash_seq),
        .tail_idx     (sq_tail_idx),
        .head_idx     (head_idx),
        .count        (sq_count),
        .full         (sq_full),
        .head_valid   (head_valid),
        .head_ready   (head_ready),
        .head_seq     (head_seq),
        .head_addr    (head_addr),
        .head_data    (head_data),
        .head_size    (head_size),
        .head_swap    (head_swap),
        .head_locked  (head_locked)
    );

    sqwb_cmd_select u_cmd (
        .is_swap   (head_swap),
        .is_locked (head_locked),
        .cmd       (head_cmd),
        .is_stcond (head_is_sc)
    );

    sqwb_retry_hold #(
        .AW (AW),
        .DW (DW)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .release_en (release_en),
        .in_cmd     (head_cmd),
        .in_addr    (head_addr),
        .in_data    (head_data),
        .in_size    (head_size),
        .blocked    (blocked),
        .held_cmd   (held_cmd),
        .held_addr  (held_addr),
        .held_data  (held_data),
        .held_size  (held_size)
    );

    // Issue decision for the head entry.
    assign issue_ok    = head_valid && head_ready && !blocked;
    assign sc_fail_now = issue_ok && head_is_sc && !resv_ok;
    assign fresh_req   = issue_ok && !sc_fail_now;

    // Request mux: held copy during a retry, head entry otherwise.
    always_comb begin
        if (blocked) begin
            req_valid = retry_pulse;
            req_cmd   = held_cmd;
            req_addr  = held_addr;
            req_data  = held_data;
            req_size  = held_size;
        end else begin
            req_valid = fresh_req;
            req_cmd   = head_cmd;
            req_addr  = head_addr;
            req_data  = head_data;
            req_size  = head_size;
        end
    end

    // Handshake outcome: retire, block or release.
    assign accepted   = req_valid && req_accept;
    assign free_en    = accepted || sc_fail_now;
    assign capture_en = fresh_req && !req_accept;
    assign release_en = blocked && retry_pulse && req_accept;
    assign store_blocked = blocked;

    // Completion report one cycle after retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid   <= 1'b0;
            done_idx     <= '0;
            done_seq     <= '0;
            done_sc_fail <= 1'b0;
        end else begin
            done_valid   <= free_en;
            done_idx     <= head_idx;
            done_seq     <= head_seq;
            done_sc_fail <= sc_fail_now;
        end
    end

endmodule

// File: rtl/sqwb_wb_checker.sv
// Protocol checks for the writeback controller, bound to its top module.
// Assumes: observes ports only.
module sqwb_wb_checker #(
    parameter  int DEPTH = 8,
    localparam int CNTW  = $clog2(DEPTH) + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_accept,
    input logic [1:0]      req_cmd,
    input logic            retry_pulse,
    input logic            store_blocked,
    input logic            done_valid,
    input logic            done_sc_fail,
    input logic [CNTW-1:0] sq_count
);

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sq_count <= CNTW'(DEPTH));

    // R4
    cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_cmd != 2'd3));

    // R5
    scfail_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_sc_fail |-> !$past(req_valid));

    // R6
    accept_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_accept) |=> (done_valid && !done_sc_fail));

    // R6
    scfail_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_sc_fail |-> done_valid);

    // R7
    refuse_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_accept && !store_blocked) |=> store_blocked);

    // R8
    blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_blocked && !retry_pulse) |-> !req_valid);

    // R8
    retry_resend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_blocked && retry_pulse) |-> req_valid);

    // R8
    retry_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_blocked && retry_pulse && req_accept) |=> !store_blocked);

    // R9
    refused_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_blocked && !(retry_pulse && req_accept)) |=> !done_valid);

endmodule

bind sqwb_writeback_ctrl sqwb_wb_checker #(.DEPTH(DEPTH)) u_wb_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_accept    (req_accept),
    .req_cmd       (req_cmd),
    .retry_pulse   (retry_pulse),
    .store_blocked (store_blocked),
    .done_valid    (done_valid),
    .done_sc_fail  (done_sc_fail),
    .sq_count      (sq_count)
);

// File: tb/tb_sqwb_writeback_ctrl.sv
module tb_sqwb_writeback_ctrl;

    localparam int DEPTH = 4;
    localparam int AW    = 16;
    localparam int DW    = 32;
    localparam int SEQW  = 8;
    localparam int IDXW  = $clog2(DEPTH);
    localparam int CNTW  = IDXW + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            alloc_valid = 1'b0;
    logic [SEQW-1:0] alloc_seq = '0;
    logic [AW-1:0]   alloc_addr = '0;
    logic [DW-1:0]   alloc_data = '0;
    logic [1:0]      alloc_size = '0;
    logic            alloc_swap = 1'b0;
    logic            alloc_locked = 1'b0;
    logic [IDXW-1:0] sq_tail_idx;
    logic [CNTW-1:0] sq_count;
    logic            sq_full;
    logic            commit_valid = 1'b0;
    logic [IDXW-1:0] commit_idx = '0;
    logic            squash_valid = 1'b0;
    logic [SEQW-1:0] squash_seq = '0;
    logic            resv_ok = 1'b1;
    logic            req_valid;
    logic [1:0]      req_cmd;
    logic [AW-1:0]   req_addr;
    logic [DW-1:0]   req_data;
    logic [1:0]      req_size;
    logic            req_accept = 1'b1;
    logic            retry_pulse = 1'b0;
    logic            store_blocked;
    logic            done_valid;
    logic [IDXW-1:0] done_idx;
    logic [SEQW-1:0] done_seq;
    logic            done_sc_fail;

    int n_cmp = 0;
    int n_bad = 0;

    sqwb_writeback_ctrl #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .SEQW(SEQW)) dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_addr(alloc_addr),
        .alloc_data(alloc_data), .alloc_size(alloc_size), .alloc_swap(alloc_swap),
        .alloc_locked(alloc_locked), .sq_tail_idx(sq_tail_idx), .sq_count(sq_count),
        .sq_full(sq_full), .commit_valid(commit_valid), .commit_idx(commit_idx),
        .squash_valid(squash_valid), .squash_seq(squash_seq), .resv_ok(resv_ok),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
        .req_data(req_data), .req_size(req_size), .req_accept(req_accept),
        .retry_pulse(retry_pulse), .store_blocked(store_blocked),
        .done_valid(done_valid), .done_idx(done_idx), .done_seq(done_seq),
        .done_sc_fail(done_sc_fail)
    );

    // 50 MHz clock
    always #10 clk = ~clk;

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // Advance to 5 ns after the next rising edge.
    task automatic cyc();
        @(posedge clk);
        #5;
    endtask

    task automatic do_alloc(input logic [SEQW-1:0] s, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input logic [1:0] sz,
                            input logic sw, input logic lk, output logic [IDXW-1:0] idx);
        idx          = sq_tail_idx;
        alloc_valid  = 1'b1;
        alloc_seq    = s;
        alloc_addr   = a;
        alloc_data   = d;
        alloc_size   = sz;
        alloc_swap   = sw;
        alloc_locked = lk;
        cyc();
        alloc_valid  = 1'b0;
    endtask

    task automatic do_commit(input logic [IDXW-1:0] idx);
        commit_valid = 1'b1;
        commit_idx   = idx;
        cyc();
        commit_valid = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        chk("R1 count", sq_count, 0);
        chk("R1 full", sq_full, 0);
        chk("R1 blocked", store_blocked, 0);
        chk("R1 req_valid", req_valid, 0);
        chk("R1 done_valid", done_valid, 0);
        chk("R1 tail", sq_tail_idx, 0);
    endtask

    task automatic t_plain_write();
        logic [IDXW-1:0] i;
        do_alloc(8'd1, 16'h0100, 32'h1111_2222, 2'd2, 1'b0, 1'b0, i);
        chk("R2 count after alloc", sq_count, 1);
        #1;
        chk("R3 uncommitted not issued", req_valid, 0);
        do_commit(i);
        chk("R3 req_valid", req_valid, 1);
        chk("R4 plain cmd", req_cmd, 0);
        chk("R3 addr", req_addr, 16'h0100);
        chk("R3 data", req_data, 32'h1111_2222);
        chk("R3 size", req_size, 2);
        cyc();
        chk("R6 done_valid", done_valid, 1);
        chk("R6 done_idx", done_idx, i);
        chk("R6 done_seq", done_seq, 1);
        chk("R6 sc_fail clear", done_sc_fail, 0);
        chk("R9 count after accept", sq_count, 0);
        cyc();
        chk("R6 single pulse", done_valid, 0);
    endtask

    task automatic t_cmd_select();
        logic [IDXW-1:0] i;
        do_alloc(8'd2, 16'h0200, 32'hA5A5_0002, 2'd3, 1'b1, 1'b1, i);
        do_commit(i);
        chk("R4 swap wins", req_cmd, 2);
        cyc();
        cyc();
        resv_ok = 1'b1;
        do_alloc(8'd3, 16'h0204, 32'hA5A5_0003, 2'd2, 1'b0, 1'b1, i);
        do_commit(i);
        chk("R4 stcond cmd", req_cmd, 1);
        chk("R4 stcond req", req_valid, 1);
        cyc();
        chk("R6 sc ok done", done_valid, 1);
        chk("R6 sc ok flag", done_sc_fail, 0);
        cyc();
    endtask

    task automatic t_sc_fail();
        logic [IDXW-1:0] i;
        logic [IDXW-1:0] j;
        resv_ok = 1'b0;
        do_alloc(8'd4, 16'h0400, 32'hDEAD_0004, 2'd2, 1'b0, 1'b1, i);
        do_commit(i);
        chk("R5 no cache request", req_valid, 0);
        cyc();
        chk("R5 retired locally", sq_count, 0);
        chk("R6 fail done", done_valid, 1);
        chk("R6 fail flag", done_sc_fail, 1);
        chk("R6 fail seq", done_seq, 4);
        resv_ok = 1'b1;
        do_alloc(8'd5, 16'h0500, 32'h0000_0005, 2'd1, 1'b0, 1'b0, j);
        do_commit(j);
        chk("R5 head advanced", req_addr, 16'h0500);
        cyc();
        cyc();
    endtask

    task automatic t_blocked();
        logic [IDXW-1:0] a;
        logic [IDXW-1:0] b;
        req_accept = 1'b0;
        do_alloc(8'd30, 16'h0300, 32'h3030_3030, 2'd2, 1'b0, 1'b0, a);
        do_alloc(8'd31, 16'h0310, 32'h3131_3131, 2'd2, 1'b0, 1'b0, b);
        do_commit(a);
        chk("R7 first try", req_addr, 16'h0300);
        cyc();
        chk("R7 blocked set", store_blocked, 1);
        chk("R8 quiet while blocked", req_valid, 0);
        do_commit(b);
        chk("R8 later ready held back", req_valid, 0);
        retry_pulse = 1'b1;
        #1;
        chk("R8 retry resends", req_valid, 1);
        chk("R8 held addr", req_addr, 16'h0300);
        chk("R8 held data", req_data, 32'h3030_3030);
        cyc();
        retry_pulse = 1'b0;
        chk("R8 still blocked", store_blocked, 1);
        chk("R9 no advance on refusal", sq_count, 2);
        chk("R9 no completion on refusal", done_valid, 0);
        retry_pulse = 1'b1;
        req_accept  = 1'b1;
        cyc();
        retry_pulse = 1'b0;
        #1;
        chk("R8 blocked cleared", store_blocked, 0);
        chk("R6 retried done seq", done_seq, 30);
        chk("R9 advance on accept", sq_count, 1);
        chk("R3 next in order", req_addr, 16'h0310);
        cyc();
        chk("R6 second done seq", done_seq, 31);
        chk("R9 drained", sq_count, 0);
        cyc();
    endtask

    task automatic t_full_wrap();
        logic [IDXW-1:0] ix [4];
        logic [IDXW-1:0] dummy;
        logic [IDXW-1:0] t_before;
        for (int k = 0; k < 4; k++) begin
            do_alloc(8'(50 + k), 16'(16'h0500 + 16'(k) * 16'h10), 32'(k), 2'd2, 1'b0, 1'b0, ix[k]);
        end
        chk("R2 full flag", sq_full, 1);
        chk("R2 full count", sq_count, 4);
        t_before = sq_tail_idx;
        do_alloc(8'd54, 16'h0FFF, 32'hFFFF_FFFF, 2'd0, 1'b0, 1'b0, dummy);
        chk("R2 ignored when full", sq_count, 4);
        chk("R2 tail unchanged when full", sq_tail_idx, t_before);
        for (int k = 3; k > 0; k--) begin
            do_commit(ix[k]);
            chk("R3 order held", req_valid, 0);
        end
        do_commit(ix[0]);
        for (int k = 0; k < 4; k++) begin
            cyc();
            chk("R3 drain order", done_seq, 50 + k);
        end
        chk("R2 empty after drain", sq_count, 0);
        cyc();
    endtask

    task automatic t_squash();
        logic [IDXW-1:0] p;
        logic [IDXW-1:0] q;
        logic [IDXW-1:0] r;
        do_alloc(8'd60, 16'h0600, 32'h60, 2'd2, 1'b0, 1'b0, p);
        do_alloc(8'd61, 16'h0610, 32'h61, 2'd2, 1'b0, 1'b0, q);
        do_alloc(8'd62, 16'h0620, 32'h62, 2'd2, 1'b0, 1'b0, q);
        squash_valid = 1'b1;
        squash_seq   = 8'd60;
        alloc_valid  = 1'b1;
        alloc_seq    = 8'd99;
        cyc();
        squash_valid = 1'b0;
        alloc_valid  = 1'b0;
        chk("R10 count rolled back", sq_count, 1);
        chk("R10 tail rolled back", sq_tail_idx, IDXW'(p + 1));
        do_commit(p);
        chk("R10 survivor issues", req_addr, 16'h0600);
        cyc();
        chk("R10 survivor done", done_seq, 60);
        #1;
        chk("R10 removed entries not issued", req_valid, 0);
        do_alloc(8'd63, 16'h0630, 32'h63, 2'd2, 1'b0, 1'b0, r);
        chk("R10 reuse slot", r, IDXW'(p + 1));
        do_commit(r);
        cyc();
        chk("R10 new entry done", done_seq, 63);
        cyc();
    endtask

    initial begin
        #(200000 * 20);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        #1;
        t_reset();
        cyc();
        t_plain_write();
        t_cmd_select();
        t_sc_fail();
        t_blocked();
        t_full_wrap();
        t_squash();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule